// File: doc/BRIEF.md
# Interleaved Two-Bank Flash Read Controller

This block connects a 32-bit system read bus to a flash array that is read through two independent ports. Even words sit behind port 0 and odd words behind port 1. A single configuration bit picks one of two array speeds. When the array answers within the request cycle, the controller simply steers each request to the right port and answers at once. When the array needs one wait state, the controller staggers accesses across the two ports so that a sequential burst still yields one word on every clock after the first.

In wait-state mode, a read of a port is valid only once that port has held the same index for two consecutive cycles. While one port returns word N, the controller already points the other port at word N+1. A sequential request for that word then finds it ready and completes in its own cycle. Any non-sequential access, address jump or idle cycle loses the staggered word, and the controller starts again with a single wait cycle.

Top module: `flrd_read_ctl`

## Requirements
- R1: Bus addresses are byte addresses with bits 1:0 zero. Byte address bit 2 selects the port (0 gives port 0, 1 gives port 1), and the port index is the byte address shifted right by 3.
- R2: With `cfg_ws1` low, a read raises `bus_ready` in the same cycle as `bus_rd` and returns the selected port's data. Only the selected port is enabled.
- R3: With `cfg_ws1` high, a read that does not hit a staggered word holds `bus_ready` low for exactly one cycle. It then completes in the next cycle with the word's data, provided the request is held.
- R4: With `cfg_ws1` high, after the first beat each back-to-back sequential request (`bus_seq` high) for the next word completes in its own cycle, one word per clock. This holds for bursts that start on even or odd words.
- R5: With `cfg_ws1` high, in every cycle that completes word N the other port is enabled with the index of word N+1. The word after the highest word is word 0.
- R6: With `cfg_ws1` high, a sequential request whose address is not the word after the previous beat takes the one-cycle penalty.
- R7: With `cfg_ws1` high, a non-sequential request (`bus_seq` low) takes the one-cycle penalty even when it names the staggered word.
- R8: While `bus_rd` is low both ports are disabled. With `cfg_ws1` high, a request after an idle cycle takes the one-cycle penalty even when `bus_seq` is high.
- R9: `bus_rdata` is zero in every cycle in which `bus_ready` is low.
- R10: After reset, with `bus_rd` low, `bus_ready`, `p0_en`, `p1_en` and `bus_rdata` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ws1 | input | 1 | 1 selects the one-wait-state array, 0 selects zero wait states |
| bus_rd | input | 1 | Read request, held until `bus_ready` |
| bus_seq | input | 1 | Hint that this request follows the previous beat |
| bus_addr | input | ADDR_W | Byte address of the requested word |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Request completes this cycle |
| p0_en | output | 1 | Port 0 (even words) read enable |
| p0_idx | output | ADDR_W-3 | Port 0 word index |
| p0_rdata | input | DATA_W | Port 0 read data |
| p1_en | output | 1 | Port 1 (odd words) read enable |
| p1_idx | output | ADDR_W-3 | Port 1 word index |
| p1_rdata | input | DATA_W | Port 1 read data |

## Verification
The bench builds the block with `ADDR_W` = 8, which gives 64 words and 32 indices per port. A burst can therefore run from word 62 across the top of the space into words 0 and 1, which exercises the wrap of the staggered word. `DATA_W` stays at 32. A behavioural array in the bench answers each port at once when `cfg_ws1` is low. When it is high, the array returns valid data only after a port has held its index for two cycles and returns a poison value otherwise, so any mistimed stagger shows up as wrong data.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

    typedef struct packed {
        logic pend;
    } ctl_t;

endpackage

// File: rtl/flrd_bank_track.sv
module flrd_bank_track #(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_en,
    input  logic [IDX_W-1:0] drv_idx,
    input  logic [IDX_W-1:0] ask_idx,
    output logic             armed
);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d.en  = drv_en;
        trk_d.idx = drv_en ? drv_idx : trk_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // Port held this index through the previous cycle: the slow array is settled.
    assign armed = trk_q.en && (trk_q.idx == ask_idx);

endmodule

// File: rtl/flrd_steer.sv
module flrd_steer
    import flrd_pkg::*;
#(
    parameter int WORD_W = 14,
    localparam int IDX_W = WORD_W - 1
) (
    input  logic                  rd,
    input  logic                  ws1,
    input  logic                  serve,
    input  logic [WORD_W-1:0]     word,
    output logic [1:0]            port_en,
    output logic [1:0][IDX_W-1:0] port_idx
);

    bank_e             cur_bank;
    bank_e             nxt_bank;
    logic [WORD_W-1:0] nxt_word;

    always_comb begin
        nxt_word = word + WORD_W'(1);
        cur_bank = bank_e'(word[0]);
        nxt_bank = bank_e'(nxt_word[0]);
        port_en  = '0;
        port_idx = '0;
        if (rd) begin
            port_en[cur_bank]  = 1'b1;
            port_idx[cur_bank] = word[WORD_W-1:1];
            if (ws1 && serve) begin
                port_en[nxt_bank]  = 1'b1;
                port_idx[nxt_bank] = nxt_word[WORD_W-1:1];
            end
        end
    end

endmodule

// File: rtl/flrd_read_ctl.sv
module flrd_read_ctl
    import flrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int WORD_W = ADDR_W - 2,
    localparam int IDX_W  = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ws1,
    input  logic              bus_rd,
    input  logic              bus_seq,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              p0_en,
    output logic [IDX_W-1:0]  p0_idx,
    input  logic [DATA_W-1:0] p0_rdata,
    output logic              p1_en,
    output logic [IDX_W-1:0]  p1_idx,
    input  logic [DATA_W-1:0] p1_rdata
);

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0]     word;
    bank_e                 cur_bank;
    logic [1:0]            armed;
    logic [1:0]            port_en;
    logic [1:0][IDX_W-1:0] port_idx;
    logic                  hit;

    assign word     = bus_addr[ADDR_W-1:2];
    assign cur_bank = bank_e'(word[0]);

    generate
        for (genvar g = 0; g < 2; g++) begin : g_trk
            flrd_bank_track #(.IDX_W(IDX_W)) u_trk (
                .clk     (clk),
                .rst_n   (rst_n),
                .drv_en  (port_en[g]),
                .drv_idx (port_idx[g]),
                .ask_idx (word[WORD_W-1:1]),
                .armed   (armed[g])
            );
        end
    endgenerate

    always_comb begin
        hit       = armed[cur_bank] && (bus_seq || ctl_q.pend);
        bus_ready = bus_rd && (!cfg_ws1 || hit);
        bus_rdata = '0;
        if (bus_ready) bus_rdata = (cur_bank == BANK_ODD) ? p1_rdata : p0_rdata;
        ctl_d.pend = cfg_ws1 && bus_rd && !bus_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    flrd_steer #(.WORD_W(WORD_W)) u_steer (
        .rd       (bus_rd),
        .ws1      (cfg_ws1),
        .serve    (bus_ready),
        .word     (word),
        .port_en  (port_en),
        .port_idx (port_idx)
    );

    assign p0_en  = port_en[0];
    assign p0_idx = port_idx[0];
    assign p1_en  = port_en[1];
    assign p1_idx = port_idx[1];

    // R1: requests are word aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[1:0] == 2'b00));

    // R2: zero-wait mode always completes at once
    a_r2_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ws1 && bus_rd) |-> bus_ready);

    // R3: data in wait-state mode comes only from a port held since last cycle
    a_r3_even_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ws1 && bus_ready && !bus_addr[2]) |->
        ($past(p0_en) && ($past(p0_idx) == bus_addr[ADDR_W-1:3])));
    a_r3_odd_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ws1 && bus_ready && bus_addr[2]) |->
        ($past(p1_en) && ($past(p1_idx) == bus_addr[ADDR_W-1:3])));

    // R3: the penalty never lasts more than one cycle
    a_r3_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ws1 && $past(cfg_ws1) && bus_rd && $past(bus_rd && !bus_ready)
         && $stable(bus_addr)) |-> bus_ready);

    // R7: a fresh non-sequential request waits
    a_r7_nonseq_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ws1 && bus_rd && !bus_seq && !$past(bus_rd && !bus_ready)) |-> !bus_ready);

    // R8: no port activity without a request
    a_r8_idle_ports: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (!p0_en && !p1_en));

    // R9: data stays quiet while not ready
    a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> (bus_rdata == '0));

endmodule

// File: tb/tb_flrd_read_ctl.sv
module tb_flrd_read_ctl;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int WW = AW - 2;
    localparam int IW = AW - 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_ws1 = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_seq = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          p0_en, p1_en;
    logic [IW-1:0] p0_idx, p1_idx;
    logic [DW-1:0] p0_rdata, p1_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flrd_read_ctl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ws1(cfg_ws1), .bus_rd(bus_rd),
        .bus_seq(bus_seq), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .p0_en(p0_en), .p0_idx(p0_idx),
        .p0_rdata(p0_rdata), .p1_en(p1_en), .p1_idx(p1_idx), .p1_rdata(p1_rdata)
    );

    // Behavioural array: slow mode needs the index held for two cycles.
    logic          pv0_en = 1'b0, pv1_en = 1'b0;
    logic [IW-1:0] pv0_idx = '0, pv1_idx = '0;

    always_ff @(posedge clk) begin
        pv0_en <= p0_en; pv0_idx <= p0_idx;
        pv1_en <= p1_en; pv1_idx <= p1_idx;
    end

    function automatic logic [DW-1:0] word_val(input logic [WW-1:0] w);
        return 32'hC3A5_0000 + {26'd0, w} * 32'h0003_0101;
    endfunction

    always_comb begin
        if (!p0_en) p0_rdata = 32'hDEAD_0000;
        else if (!cfg_ws1 || (pv0_en && pv0_idx == p0_idx)) p0_rdata = word_val({p0_idx, 1'b0});
        else p0_rdata = 32'hDEAD_0001;
        if (!p1_en) p1_rdata = 32'hDEAD_0000;
        else if (!cfg_ws1 || (pv1_en && pv1_idx == p1_idx)) p1_rdata = word_val({p1_idx, 1'b1});
        else p1_rdata = 32'hDEAD_0001;
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One beat: request word w, expect `waits` withheld cycles, then check data and ports.
    task automatic do_beat(input logic [WW-1:0] w, input logic s, input int waits,
                           input string req);
        logic [WW-1:0] nw;
        logic          oth_en;
        logic [IW-1:0] oth_idx;
        logic          cur_en;
        logic [IW-1:0] cur_idx;
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_seq = s; bus_addr = {w, 2'b00};
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check(!bus_ready, {req, " wait cycle ready"}, {31'd0, bus_ready}, 0);
            check(bus_rdata == 0, "R9 rdata zero while waiting", bus_rdata, 0);
            @(posedge clk); #1;
        end
        @(negedge clk);
        check(bus_ready, {req, " ready"}, {31'd0, bus_ready}, 1);
        check(bus_rdata == word_val(w), {req, " data"}, bus_rdata, word_val(w));
        cur_en  = w[0] ? p1_en  : p0_en;
        cur_idx = w[0] ? p1_idx : p0_idx;
        check(cur_en && cur_idx == w[WW-1:1], "R1 selected port and index",
              {27'd0, cur_idx}, {27'd0, w[WW-1:1]});
        oth_en  = w[0] ? p0_en  : p1_en;
        oth_idx = w[0] ? p0_idx : p1_idx;
        nw = w + 6'd1;
        if (cfg_ws1)
            check(oth_en && oth_idx == nw[WW-1:1], "R5 next word launched on other port",
                  {26'd0, oth_en, oth_idx}, {26'd0, 1'b1, nw[WW-1:1]});
        else
            check(!oth_en, "R2 other port idle", {31'd0, oth_en}, 0);
    endtask

    task automatic go_idle();
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_seq = 1'b0;
        @(negedge clk);
        check(!p0_en && !p1_en, "R8 ports off while idle", {30'd0, p1_en, p0_en}, 0);
        check(!bus_ready, "R8 not ready while idle", {31'd0, bus_ready}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!bus_ready, "R10 ready low", {31'd0, bus_ready}, 0);
        check(!p0_en && !p1_en, "R10 ports off", {30'd0, p1_en, p0_en}, 0);
        check(bus_rdata == 0, "R10 rdata zero", bus_rdata, 0);
    endtask

    task automatic t_zero_wait();
        cfg_ws1 = 1'b0;
        do_beat(6'd5, 1'b0, 0, "R2 odd word");
        do_beat(6'd2, 1'b0, 0, "R2 even word");
        do_beat(6'd3, 1'b1, 0, "R2 sequential");
        do_beat(6'd9, 1'b1, 0, "R2 jump");
        go_idle();
    endtask

    task automatic t_single();
        cfg_ws1 = 1'b1;
        do_beat(6'd10, 1'b0, 1, "R3 single read");
        go_idle();
    endtask

    task automatic t_burst_even();
        do_beat(6'd4, 1'b0, 1, "R3 burst start");
        for (int k = 5; k <= 8; k++) do_beat(6'(k), 1'b1, 0, "R4 even burst beat");
        go_idle();
    endtask

    task automatic t_burst_odd();
        do_beat(6'd11, 1'b0, 1, "R3 odd burst start");
        do_beat(6'd12, 1'b1, 0, "R4 odd burst beat");
        do_beat(6'd13, 1'b1, 0, "R4 odd burst beat");
        go_idle();
    endtask

    task automatic t_break();
        do_beat(6'd20, 1'b0, 1, "R3 start");
        do_beat(6'd21, 1'b1, 0, "R4 beat");
        do_beat(6'd30, 1'b1, 1, "R6 address break");
        do_beat(6'd31, 1'b1, 0, "R4 after break");
        go_idle();
    endtask

    task automatic t_nonseq_prefetched();
        do_beat(6'd40, 1'b0, 1, "R3 start");
        do_beat(6'd41, 1'b0, 1, "R7 nonseq on staggered word");
        go_idle();
    endtask

    task automatic t_idle_gap();
        do_beat(6'd50, 1'b0, 1, "R3 start");
        go_idle();
        do_beat(6'd51, 1'b1, 1, "R8 seq after idle");
        go_idle();
    endtask

    task automatic t_wrap();
        do_beat(6'd62, 1'b0, 1, "R3 start near top");
        do_beat(6'd63, 1'b1, 0, "R5 top word");
        do_beat(6'd0,  1'b1, 0, "R5 wrapped word 0");
        do_beat(6'd1,  1'b1, 0, "R4 after wrap");
        go_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_zero_wait();
        t_single();
        t_burst_even();
        t_burst_odd();
        t_break();
        t_nonseq_prefetched();
        t_idle_gap();
        t_wrap();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule